// File: doc/BRIEF.md
# E1 Timeslot Cross-Connect

This block moves timeslots between a set of slot-aligned E1 ports. Each port feeds one received byte and one 4-bit signaling nibble per timeslot. Each port also produces one transmitted byte and nibble per timeslot. Every outgoing timeslot of every port has its own map entry. The entry names the source port and source timeslot to copy, or marks the slot as disconnected. A source may be any slot of any port, including a slot on the same port, so any rearrangement can be built and loopbacks are possible.

Received bytes and nibbles go into a frame store with two banks. During one frame the block fills one bank and reads the other. The banks swap at each frame start, so an outgoing frame always carries the complete previous incoming frame. Software writes map entries into a shadow copy at any time. The whole shadow copy becomes the active map at the next frame start. A port placed in unstructured mode skips the map and echoes its own receive stream.

All ports share one slot strobe and one frame-start strobe. The strobe timing fixes the slot number; the block keeps no framing state of its own.

Top module: `e1_xconnect`

## Requirements
- R1: While reset is asserted and after its release, before any slot strobe, `tx_valid` is 0, every transmit byte is 0xFF and every transmit nibble is 4'b1101.
- R2: For a connected output slot, the byte sent in slot k of frame N+1 equals the byte that the named source port received in the named source slot during frame N.
- R3: A map entry whose source port equals its own output port is honoured like any other entry, which gives a loopback.
- R4: A map write takes effect at the first frame-start strobe after the write. Slots of the frame in progress keep the old mapping.
- R5: The transmitted nibble always comes from the same source port, slot and frame as the transmitted byte.
- R6: An output slot whose entry is disconnected (never written since reset, or written with `cfg_connect`=0) sends 0xFF with nibble 4'b1101.
- R7: While `unstr[p]` is 1, port p transmits, one cycle after each slot strobe, the byte and nibble it received on that strobe, whatever its map holds.
- R8: The slot number is 0 on a strobe with `frame_start`=1 and counts up by one on each later strobe. Data written in one frame never appears in the same frame's output.
- R9: `tx_valid` is 1 exactly in the cycle after a slot strobe. Transmit bytes and nibbles hold their values in cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_en | input | 1 | One timeslot is present on all receive ports |
| frame_start | input | 1 | With slot_en: this is slot 0 of a new frame |
| rx_data | input | NPORTS*8 | Received byte per port, port p at bits [8p+7:8p] |
| rx_cas | input | NPORTS*4 | Received signaling nibble per port, port p at [4p+3:4p] |
| unstr | input | NPORTS | Per-port unstructured (bypass) mode |
| cfg_we | input | 1 | Write one shadow map entry |
| cfg_out_port | input | PW | Output port of the entry |
| cfg_out_slot | input | SW | Output slot of the entry |
| cfg_connect | input | 1 | 1 = connect to source, 0 = disconnect |
| cfg_src_port | input | PW | Source port |
| cfg_src_slot | input | SW | Source slot |
| tx_data | output | NPORTS*8 | Transmitted byte per port |
| tx_cas | output | NPORTS*4 | Transmitted signaling nibble per port |
| tx_valid | output | 1 | Transmit outputs carry a new slot |

## Verification
The assertions check the properties that hold on every cycle. `tx_valid` follows the strobe, and outputs hold between strobes. The active map and the bank select change only on a frame-start strobe, and the bank select toggles on each one. An unstructured port echoes its input. The bench's scenarios are needed for the properties that span whole frames. These are the arbitrary source routing, the loopback, the disconnected-slot pattern and the one-frame delay. They also include a map write in the middle of a frame, whose slots keep the old routing until the next frame.

// File: rtl/e1x_pkg.sv
package e1x_pkg;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam logic [3:0] IDLE_CAS  = 4'b1101;
  localparam int         WORD_W    = 12;  // {cas[3:0], data[7:0]}
endpackage

// File: rtl/e1x_slot_timer.sv
module e1x_slot_timer #(
  parameter int NSLOTS = 32,
  localparam int SW = $clog2(NSLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_en,
  input  logic          frame_start,
  output logic [SW-1:0] cur_slot,
  output logic          wr_bank,
  output logic          bank_q
);
  logic [SW-1:0] cnt_q, cnt_d;
  logic          bank_d;
  logic          load;

  always_comb begin
    load     = slot_en & frame_start;
    cur_slot = load ? '0 : cnt_q;
    wr_bank  = load ? ~bank_q : bank_q;
    bank_d   = wr_bank;
    cnt_d    = cnt_q;
    if (slot_en) begin
      if (cur_slot == SW'(NSLOTS - 1)) cnt_d = '0;
      else                             cnt_d = cur_slot + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bank_q <= bank_d;
    end
  end
endmodule

// File: rtl/e1x_map.sv
module e1x_map #(
  parameter int NPORTS = 2,
  parameter int NSLOTS = 32,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int SW = $clog2(NSLOTS),
  localparam int EW = 1 + PW + SW,
  localparam int NENT = NPORTS * NSLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [PW-1:0]        cfg_out_port,
  input  logic [SW-1:0]        cfg_out_slot,
  input  logic [EW-1:0]        cfg_entry,
  input  logic                 load,
  input  logic [SW-1:0]        rd_slot,
  output logic [NPORTS*EW-1:0] sel_flat,
  output logic [NENT*EW-1:0]   act_flat
);
  logic [EW-1:0] shadow_q [NENT];
  logic [EW-1:0] shadow_d [NENT];
  logic [EW-1:0] active_q [NENT];
  logic [EW-1:0] active_d [NENT];

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      shadow_d[i] = shadow_q[i];
      active_d[i] = load ? shadow_q[i] : active_q[i];
    end
    if (cfg_we) shadow_d[int'(cfg_out_port) * NSLOTS + int'(cfg_out_slot)] = cfg_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NENT; i++) begin
        shadow_q[i] <= shadow_d[i];
        active_q[i] <= active_d[i];
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_sel
    assign sel_flat[p*EW +: EW] = load ? shadow_q[p*NSLOTS + int'(rd_slot)]
                                       : active_q[p*NSLOTS + int'(rd_slot)];
  end
  for (genvar i = 0; i < NENT; i++) begin : g_act
    assign act_flat[i*EW +: EW] = active_q[i];
  end
endmodule

// File: rtl/e1x_store.sv
module e1x_store #(
  parameter int NPORTS = 2,
  parameter int NSLOTS = 32,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int SW = $clog2(NSLOTS),
  localparam int AW = PW + SW,
  localparam int WW = e1x_pkg::WORD_W,
  localparam int DEPTH = 2 * NPORTS * NSLOTS
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic                 wr_bank,
  input  logic [SW-1:0]        wr_slot,
  input  logic [NPORTS*WW-1:0] wr_word,
  input  logic                 rd_bank,
  input  logic [NPORTS*AW-1:0] rd_addr,
  output logic [NPORTS*WW-1:0] rd_word
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int p = 0; p < NPORTS; p++)
        mem[int'(wr_bank) * NPORTS * NSLOTS + p * NSLOTS + int'(wr_slot)] <= wr_word[p*WW +: WW];
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    logic [PW-1:0] sp;
    logic [SW-1:0] ss;
    assign {sp, ss} = rd_addr[p*AW +: AW];
    assign rd_word[p*WW +: WW] = mem[int'(rd_bank) * NPORTS * NSLOTS + int'(sp) * NSLOTS + int'(ss)];
  end
endmodule

// File: rtl/e1_xconnect.sv
module e1_xconnect #(
  parameter int NPORTS = 2,
  parameter int NSLOTS = 32,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int SW = $clog2(NSLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_en,
  input  logic                 frame_start,
  input  logic [NPORTS*8-1:0]  rx_data,
  input  logic [NPORTS*4-1:0]  rx_cas,
  input  logic [NPORTS-1:0]    unstr,
  input  logic                 cfg_we,
  input  logic [PW-1:0]        cfg_out_port,
  input  logic [SW-1:0]        cfg_out_slot,
  input  logic                 cfg_connect,
  input  logic [PW-1:0]        cfg_src_port,
  input  logic [SW-1:0]        cfg_src_slot,
  output logic [NPORTS*8-1:0]  tx_data,
  output logic [NPORTS*4-1:0]  tx_cas,
  output logic                 tx_valid
);
  import e1x_pkg::*;
  localparam int EW = 1 + PW + SW;
  localparam int AW = PW + SW;
  localparam int WW = WORD_W;
  localparam int NENT = NPORTS * NSLOTS;

  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic                 load;
  logic [SW-1:0]        cur_slot;
  logic                 wr_bank, bank_q;
  logic [NPORTS*EW-1:0] sel_flat;
  logic [NENT*EW-1:0]   act_flat;
  logic [NPORTS*WW-1:0] wr_flat, rdw_flat;
  logic [NPORTS*AW-1:0] rd_flat;

  assign load = slot_en & frame_start;

  e1x_slot_timer #(.NSLOTS(NSLOTS)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .slot_en(slot_en), .frame_start(frame_start),
    .cur_slot(cur_slot), .wr_bank(wr_bank), .bank_q(bank_q));

  e1x_map #(.NPORTS(NPORTS), .NSLOTS(NSLOTS)) u_map (
    .clk(clk), .rst_n(rst_i_n), .cfg_we(cfg_we), .cfg_out_port(cfg_out_port),
    .cfg_out_slot(cfg_out_slot), .cfg_entry({cfg_connect, cfg_src_port, cfg_src_slot}),
    .load(load), .rd_slot(cur_slot), .sel_flat(sel_flat), .act_flat(act_flat));

  e1x_store #(.NPORTS(NPORTS), .NSLOTS(NSLOTS)) u_st (
    .clk(clk), .we(slot_en), .wr_bank(wr_bank), .wr_slot(cur_slot), .wr_word(wr_flat),
    .rd_bank(~wr_bank), .rd_addr(rd_flat), .rd_word(rdw_flat));

  logic [NPORTS*8-1:0] txd_q, txd_d;
  logic [NPORTS*4-1:0] txc_q, txc_d;
  logic                txv_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [EW-1:0] ent;
    logic [WW-1:0] word;
    assign wr_flat[p*WW +: WW] = {rx_cas[p*4 +: 4], rx_data[p*8 +: 8]};
    assign ent = sel_flat[p*EW +: EW];
    assign rd_flat[p*AW +: AW] = ent[AW-1:0];
    assign word = rdw_flat[p*WW +: WW];

    always_comb begin
      txd_d[p*8 +: 8] = txd_q[p*8 +: 8];
      txc_d[p*4 +: 4] = txc_q[p*4 +: 4];
      if (slot_en) begin
        if (unstr[p]) begin
          txd_d[p*8 +: 8] = rx_data[p*8 +: 8];
          txc_d[p*4 +: 4] = rx_cas[p*4 +: 4];
        end else if (!ent[EW-1]) begin
          txd_d[p*8 +: 8] = IDLE_BYTE;
          txc_d[p*4 +: 4] = IDLE_CAS;
        end else begin
          txd_d[p*8 +: 8] = word[7:0];
          txc_d[p*4 +: 4] = word[11:8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      txd_q <= {NPORTS{IDLE_BYTE}};
      txc_q <= {NPORTS{IDLE_CAS}};
      txv_q <= 1'b0;
    end else begin
      txd_q <= txd_d;
      txc_q <= txc_d;
      txv_q <= slot_en;
    end
  end

  assign tx_data  = txd_q;
  assign tx_cas   = txc_q;
  assign tx_valid = txv_q;
endmodule

// File: rtl/e1x_checker.sv
module e1x_checker #(
  parameter int NPORTS = 2,
  parameter int ACTW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slot_en,
  input logic                frame_start,
  input logic [NPORTS*8-1:0] rx_data,
  input logic [NPORTS*4-1:0] rx_cas,
  input logic [NPORTS-1:0]   unstr,
  input logic [NPORTS*8-1:0] tx_data,
  input logic [NPORTS*4-1:0] tx_cas,
  input logic                tx_valid,
  input logic [ACTW-1:0]     act_flat,
  input logic                bank_q
);
  p_valid_after_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |=> tx_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> !tx_valid);
  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> ($stable(tx_data) && $stable(tx_cas)));
  p_map_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_en && frame_start) |=> $stable(act_flat));
  p_bank_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && frame_start) |=> (bank_q != $past(bank_q)));
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_en && frame_start) |=> $stable(bank_q));

  for (genvar p = 0; p < NPORTS; p++) begin : g_byp
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_en && unstr[p]) |=>
        (tx_data[p*8 +: 8] == $past(rx_data[p*8 +: 8]) &&
         tx_cas[p*4 +: 4]  == $past(rx_cas[p*4 +: 4])));
  end
endmodule

bind e1_xconnect e1x_checker #(.NPORTS(NPORTS), .ACTW(NENT*EW)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .slot_en(slot_en), .frame_start(frame_start),
  .rx_data(rx_data), .rx_cas(rx_cas), .unstr(unstr), .tx_data(tx_data),
  .tx_cas(tx_cas), .tx_valid(tx_valid), .act_flat(act_flat), .bank_q(bank_q));

// File: tb/e1_xconnect_bench.sv
module e1_xconnect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int NS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_en = 1'b0, frame_start = 1'b0;
  logic [NP*8-1:0] rx_data = '0;
  logic [NP*4-1:0] rx_cas = '0;
  logic [NP-1:0] unstr = '0;
  logic cfg_we = 1'b0, cfg_connect = 1'b0;
  logic [0:0] cfg_out_port = '0, cfg_src_port = '0;
  logic [4:0] cfg_out_slot = '0, cfg_src_slot = '0;
  logic [NP*8-1:0] tx_data;
  logic [NP*4-1:0] tx_cas;
  logic tx_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_xconnect #(.NPORTS(NP), .NSLOTS(NS)) u_e1_xconnect (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .frame_start(frame_start),
    .rx_data(rx_data), .rx_cas(rx_cas), .unstr(unstr), .cfg_we(cfg_we),
    .cfg_out_port(cfg_out_port), .cfg_out_slot(cfg_out_slot), .cfg_connect(cfg_connect),
    .cfg_src_port(cfg_src_port), .cfg_src_slot(cfg_src_slot),
    .tx_data(tx_data), .tx_cas(tx_cas), .tx_valid(tx_valid));

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model, built from the requirements
  bit sh_v [NP][NS]; int sh_p [NP][NS]; int sh_s [NP][NS];
  bit ac_v [NP][NS]; int ac_p [NP][NS]; int ac_s [NP][NS];
  int prv_d [NP][NS]; int prv_c [NP][NS];
  int cur_d [NP][NS]; int cur_c [NP][NS];
  bit prev_ok = 0, have_cur = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int op, input int os, input bit conn, input int sp, input int ss);
    cfg_we = 1; cfg_out_port = 1'(op); cfg_out_slot = 5'(os);
    cfg_connect = conn; cfg_src_port = 1'(sp); cfg_src_slot = 5'(ss);
    @(posedge clk); #1;
    cfg_we = 0;
    sh_v[op][os] = conn; sh_p[op][os] = sp; sh_s[op][os] = ss;
  endtask

  // one frame; optional map write during slot 10
  task automatic run_frame(input int fr, input bit mid, input int mop, input int mos,
                           input int msp, input int mss);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++) begin
        ac_v[p][s] = sh_v[p][s]; ac_p[p][s] = sh_p[p][s]; ac_s[p][s] = sh_s[p][s];
        prv_d[p][s] = cur_d[p][s]; prv_c[p][s] = cur_c[p][s];
      end
    prev_ok = have_cur; have_cur = 1;
    for (int s = 0; s < NS; s++) begin
      slot_en = 1; frame_start = (s == 0);
      for (int p = 0; p < NP; p++) begin
        cur_d[p][s] = (fr*37 + p*101 + s*3) & 255;
        cur_c[p][s] = (fr*5 + p*3 + s) & 15;
        rx_data[p*8 +: 8] = 8'(cur_d[p][s]);
        rx_cas[p*4 +: 4]  = 4'(cur_c[p][s]);
      end
      if (mid && s == 10) begin
        cfg_we = 1; cfg_out_port = 1'(mop); cfg_out_slot = 5'(mos);
        cfg_connect = 1; cfg_src_port = 1'(msp); cfg_src_slot = 5'(mss);
      end
      @(posedge clk); #1;
      if (mid && s == 10) begin
        cfg_we = 0;
        sh_v[mop][mos] = 1; sh_p[mop][mos] = msp; sh_s[mop][mos] = mss;
      end
      chk(tx_valid === 1'b1, "R9", int'(tx_valid), 1);
      for (int p = 0; p < NP; p++) begin
        int ed, ec; string tag; bit skip;
        skip = 0;
        if (unstr[p]) begin
          ed = cur_d[p][s]; ec = cur_c[p][s]; tag = "R7";
        end else if (!ac_v[p][s]) begin
          ed = 8'hFF; ec = 4'b1101; tag = "R6";
        end else begin
          ed = prv_d[ac_p[p][s]][ac_s[p][s]]; ec = prv_c[ac_p[p][s]][ac_s[p][s]];
          skip = !prev_ok;
          if (sh_v[p][s] != ac_v[p][s] || sh_p[p][s] != ac_p[p][s] || sh_s[p][s] != ac_s[p][s])
            tag = "R4";
          else if (ac_p[p][s] == p) tag = "R3,R8";
          else tag = "R2,R8";
        end
        if (!skip) begin
          chk(int'(tx_data[p*8 +: 8]) == ed, tag, int'(tx_data[p*8 +: 8]), ed);
          chk(int'(tx_cas[p*4 +: 4]) == ec, {tag, ",R5"}, int'(tx_cas[p*4 +: 4]), ec);
        end
      end
      if (s == 15) begin
        logic [NP*8-1:0] hold_d;
        hold_d = tx_data;
        slot_en = 0; frame_start = 0;
        @(posedge clk); #1;
        chk(tx_valid === 1'b0, "R9", int'(tx_valid), 0);
        chk(tx_data === hold_d, "R9", int'(tx_data), int'(hold_d));
      end
    end
    slot_en = 0; frame_start = 0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk(tx_valid === 1'b0, "R1", int'(tx_valid), 0);
    chk(tx_data === {NP{8'hFF}}, "R1", int'(tx_data), 16'hFFFF);
    chk(tx_cas === {NP{4'b1101}}, "R1", int'(tx_cas), 8'hDD);
  endtask

  task automatic t_cross();
    for (int s = 0; s < NS; s++) begin
      if (s % 2 == 0) cfg_write(0, s, 1, 1, 31 - s);
      cfg_write(1, s, 1, 0, (s + 3) % NS);
    end
    cfg_write(1, 5, 1, 1, 9);   // loopback on port 1, R3
    run_frame(0, 0, 0, 0, 0, 0);
    run_frame(1, 0, 0, 0, 0, 0);
    run_frame(2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_boundary();
    run_frame(3, 1, 0, 20, 0, 2);  // R4: slot 20 keeps old route this frame
    run_frame(4, 0, 0, 0, 0, 0);
  endtask

  task automatic t_disconnect();
    cfg_write(1, 4, 0, 0, 0);      // R6
    run_frame(5, 0, 0, 0, 0, 0);
  endtask

  task automatic t_unstr();
    unstr = 2'b10;                 // R7
    run_frame(6, 0, 0, 0, 0, 0);
    run_frame(7, 0, 0, 0, 0, 0);
    unstr = 2'b00;
    run_frame(8, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++) begin
        sh_v[p][s] = 0; sh_p[p][s] = 0; sh_s[p][s] = 0;
        cur_d[p][s] = 0; cur_c[p][s] = 0;
      end
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1 t_reset();
    t_cross();
    t_boundary();
    t_disconnect();
    t_unstr();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule